// File: doc/BRIEF.md
# Uninitialized Working-Register Pointer Trap

This block watches the sixteen general-purpose working registers of a processor core and remembers which of them software has written since the last reset. A reset of any kind marks registers 0 through 14 as uninitialized. Register 15, the stack pointer, is exempt and always counts as valid.

When the core uses a register as an address pointer, it raises a strobe together with the register's index. If that register has not been written since reset, the block asks for a device reset. The request is a one-cycle pulse issued on the cycle after the offending use. In the same cycle the block sends a cause pulse to the reset status register. The cause pulse sits on bit 14, the flag shared by illegal-opcode, uninitialized-register and security events.

The register file, the instruction decoder and the reset sequencer lie outside this block. Only the per-register valid bits and the check are modelled here.

Top module: `wreg_init_trap`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, every register with index 0 to 14 counts as unwritten. A pointer use of such a register with no earlier write raises `req_o`.
- R2: Register index 15 is always valid. A pointer use of index 15 never raises `req_o`, whatever has been written.
- R3: A pointer use (`ptr_en`=1) of an unwritten register at clock edge k drives `req_o` high for exactly the one cycle after edge k.
- R4: `cause_o` is 16 bits wide. Bit 14 is high in exactly the cycles where `req_o` is high. All other bits, and bit 14 at any other time, are zero.
- R5: A write (`wr_en`=1) to register i makes later pointer uses of i valid (no request) until the next reset. Write traffic alone never raises `req_o`.
- R6: A write and a pointer use of the same register in the same cycle count as use before initialization and raise `req_o`. A use of that register on any later cycle is valid.
- R7: After one request, no further request is raised until `rst` is asserted again. This holds even for later uses of other unwritten registers.
- R8: While `rst` is high, writes are ignored and `req_o` stays low. A reset clears all write history. Writes on the first cycle after `rst` falls are recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, asserted for every reset kind |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Index of the register being written |
| ptr_en | input | 1 | Address-pointer use strobe |
| ptr_idx | input | 4 | Index of the register used as a pointer |
| req_o | output | 1 | One-cycle device reset request |
| cause_o | output | 16 | Set pulse for the reset status register (bit 14) |

## Verification
The hardest situation to reach is a pointer use of an unwritten register after most registers have already been written. Random indices tend to initialize registers long before they are used, and a single request then silences the block until the next reset. The stimulus therefore asserts reset often and biases pointer indices toward a small set of registers that rarely see writes. Directed sequences cover three further cases: the same-cycle write and use, index 15, and a write on the first cycle after reset.

// File: rtl/wreg_init_trap.sv
module wreg_init_trap #(
  parameter int NREGS     = 16,
  parameter int IW        = $clog2(NREGS),
  parameter int SP_IDX    = NREGS - 1,
  parameter int STATW     = 16,
  parameter int CAUSE_BIT = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_idx,
  input  logic             ptr_en,
  input  logic [IW-1:0]    ptr_idx,
  output logic             req_o,
  output logic [STATW-1:0] cause_o
);

  localparam logic [NREGS-1:0] SP_MASK   = {{(NREGS-1){1'b0}}, 1'b1} << SP_IDX;
  localparam logic [STATW-1:0] CAUSE_VEC = {{(STATW-1){1'b0}}, 1'b1} << CAUSE_BIT;

  logic [NREGS-1:0] written_q;
  logic             fired_q;
  logic             req_q;

  wire [NREGS-1:0] valid = written_q | SP_MASK;
  wire             hit   = ptr_en & ~valid[ptr_idx] & ~fired_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      written_q <= '0;
      fired_q   <= 1'b0;
      req_q     <= 1'b0;
    end else begin
      if (wr_en && wr_idx != IW'(SP_IDX))
        written_q[wr_idx] <= 1'b1;
      req_q <= hit;
      if (hit)
        fired_q <= 1'b1;
    end
  end

  assign req_o   = req_q;
  assign cause_o = req_q ? CAUSE_VEC : '0;

  // R3
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |=> !req_o);

  // R3
  req_follows_use_chk: assert property (@(posedge clk) disable iff (rst)
    req_o |-> $past(ptr_en));

  // R2
  sp_never_traps_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr_en && ptr_idx == IW'(SP_IDX)) |=> !req_o);

  // R7
  one_per_epoch_chk: assert property (@(posedge clk) disable iff (rst)
    fired_q |=> !req_o);

  // R4
  cause_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cause_o) && (cause_o[CAUSE_BIT] == req_o));

endmodule

// File: tb/wreg_init_trap_bench.sv
module wreg_init_trap_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, ptr_en = 1'b0;
  logic [3:0] wr_idx = '0, ptr_idx = '0;
  logic req_o;
  logic [15:0] cause_o;

  int checks = 0, failures = 0;
  bit written[16];
  bit fired;

  always #(CLK_PERIOD/2) clk = ~clk;

  wreg_init_trap u_wreg_init_trap (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .ptr_en(ptr_en), .ptr_idx(ptr_idx), .req_o(req_o), .cause_o(cause_o)
  );

  function automatic bit exp_req(bit r, bit pe, logic [3:0] pi);
    return !r && !fired && pe && !(written[pi] || pi == 4'd15);
  endfunction

  function automatic logic [15:0] exp_cause(bit q);
    return q ? 16'h4000 : 16'h0000;
  endfunction

  task automatic check(string tag, bit exp);
    checks++;
    if (req_o !== exp) begin
      failures++;
      $display("FAIL %s req_o actual=%b expected=%b", tag, req_o, exp);
    end
    checks++;
    if (cause_o !== exp_cause(exp)) begin
      failures++;
      $display("FAIL R4 (%s) cause_o actual=%h expected=%h", tag, cause_o, exp_cause(exp));
    end
  endtask

  task automatic step(string tag, bit r, bit we, logic [3:0] wi, bit pe, logic [3:0] pi);
    bit e;
    rst = r; wr_en = we; wr_idx = wi; ptr_en = pe; ptr_idx = pi;
    e = exp_req(r, pe, pi);
    if (r) begin
      foreach (written[i]) written[i] = 1'b0;
      fired = 1'b0;
    end else begin
      if (we && wi != 4'd15) written[wi] = 1'b1;
      if (e) fired = 1'b1;
    end
    @(posedge clk); #1;
    check(tag, e);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    fired = 1'b0;
    foreach (written[i]) written[i] = 1'b0;
    @(posedge clk); #1;
    step("R8 reset state", 1, 0, 0, 0, 0);
    step("R8 write during reset ignored", 1, 1, 4'd3, 0, 0);
    step("R1 use after reset", 0, 0, 0, 1, 4'd3);
    step("R3 one cycle", 0, 0, 0, 0, 0);
    step("R8", 1, 0, 0, 0, 0);
    step("R2 sp exempt", 0, 0, 0, 1, 4'd15);
    step("R8 first-cycle write", 0, 1, 4'd5, 0, 0);
    step("R5 written ok", 0, 0, 0, 1, 4'd5);
    step("R5 writes only", 0, 1, 4'd6, 0, 0);
    step("R6 same cycle", 0, 1, 4'd7, 1, 4'd7);
    step("R7 suppressed", 0, 0, 0, 1, 4'd9);
    step("R7 held use", 0, 0, 0, 1, 4'd9);
    step("R8", 1, 0, 0, 0, 0);
    step("R6 write", 0, 1, 4'd7, 1, 4'd7);
    step("R8", 1, 0, 0, 0, 0);
    step("R6 write alone", 0, 1, 4'd7, 0, 0);
    step("R6 later use ok", 0, 0, 0, 1, 4'd7);
    step("R2 sp write harmless", 0, 1, 4'd15, 1, 4'd15);
    step("R1 reg 14", 0, 0, 0, 1, 4'd14);
    step("R3 drop", 0, 0, 0, 0, 0);
    for (int n = 0; n < 4000; n++) begin
      bit r  = ($urandom_range(39) == 0);
      bit we = $urandom_range(2) == 0;
      bit pe = $urandom_range(1) == 0;
      logic [3:0] wi = 4'($urandom_range(15));
      logic [3:0] pi = ($urandom_range(1) == 0) ? 4'($urandom_range(12, 15)) : 4'($urandom_range(15));
      if (we && $urandom_range(3) != 0 && wi >= 4'd12) wi = 4'($urandom_range(11));
      step("R3 random", r, we, wi, pe, pi);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule